// File: doc/BRIEF.md
# Conditional Token Merge Node

This block is a dataflow node that joins two data streams under the direction of a third, control, stream. Every channel (control C, data inputs A and B, output Z) uses a synchronous valid/ready handshake, and a token moves only in a cycle where both valid and ready are high at the rising clock edge. For each control token the node forwards one data token to Z. A control value of zero takes the token from A, and any nonzero value takes it from B.

Unlike a multiplexer, the node leaves the input it does not select alone. A token waiting there stays pending for as long as the control stream keeps pointing elsewhere. The node can also complete a transfer when the unselected input has no token at all. The control token and the selected data token are consumed together in one cycle. Tokens leave in the order of their control tokens. A wider merge is built by chaining several of these nodes.

The output passes through a single register stage by default (`OUT_REG = 1`). That stage accepts a new token in the same cycle its current token is taken. With `OUT_REG = 0` the node is purely combinational from inputs to Z.

Top module: `tok_merge`

## Requirements
- R1: While `c_valid` is low, `a_ready` and `b_ready` are both low, and no token is consumed from A or B.
- R2: A control token whose value is zero (all `CW` bits zero) is consumed together with a token from A. A control token with any nonzero value is consumed together with a token from B.
- R3: With the registered output, a token accepted at rising edge n appears with `z_valid` high after that edge and stays until Z accepts it. `z_data` equals the data of the selected input token.
- R4: The unselected input sees ready low for the whole cycle. A token held there stays unconsumed across any number of control tokens that select the other input.
- R5: A transfer from the selected input completes when the unselected input has no valid token.
- R6: The Z tokens are exactly the selected input tokens, taken in control-token order, with none dropped or duplicated.
- R7: While `z_valid` is high and `z_ready` is low, `z_data` holds and `z_valid` stays high. No control token is consumed while the output stage is full and Z is stalled.
- R8: Synchronous active-high reset empties the output stage: `z_valid` is low after a reset edge.
- R9: A control token is consumed in exactly the cycle the selected data token is consumed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| c_valid | input | 1 | Control token present |
| c_ready | output | 1 | Control token taken this cycle if valid |
| c_data | input | CW | Control value: zero picks A, nonzero picks B |
| a_valid | input | 1 | Data token present on A |
| a_ready | output | 1 | A token taken this cycle if valid |
| a_data | input | DW | Data on A |
| b_valid | input | 1 | Data token present on B |
| b_ready | output | 1 | B token taken this cycle if valid |
| b_data | input | DW | Data on B |
| z_valid | output | 1 | Output token present |
| z_ready | input | 1 | Downstream accepts the output token |
| z_data | output | DW | Output data |

## Verification
The assertions assume the upstream channels keep a token and its value steady until it is taken, and that `c_data` means something only while `c_valid` is high. The bench drives each channel from an indexed token list and advances an index only after an observed transfer, so every offered token stays on the wires until it is consumed. The stimulus sweeps all control values with both inputs full. It then parks a token on B under a run of zero controls, runs nonzero controls with A empty, and ends with a long pseudo-random mix of gaps and Z stalls.

// File: rtl/tmerge_pkg.sv
package tmerge_pkg;
  typedef enum logic {PICK_A = 1'b0, PICK_B = 1'b1} pick_e;
endpackage

// File: rtl/merge_steer.sv
module merge_steer
  import tmerge_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          c_valid,
  input  logic [CW-1:0] c_data,
  output logic          c_ready,
  input  logic          a_valid,
  input  logic [DW-1:0] a_data,
  output logic          a_ready,
  input  logic          b_valid,
  input  logic [DW-1:0] b_data,
  output logic          b_ready,
  input  logic          stg_ready,
  output logic          stg_valid,
  output logic [DW-1:0] stg_data
);
  pick_e         pick;
  logic          src_valid;
  logic [DW-1:0] src_data;

  // zero control value steers to A, any other value to B
  always_comb pick = (c_data == '0) ? PICK_A : PICK_B;

  always_comb begin
    case (pick)
      PICK_A:  begin src_valid = a_valid; src_data = a_data; end
      default: begin src_valid = b_valid; src_data = b_data; end
    endcase
  end

  // join: output token exists only when control and chosen data both exist
  assign stg_valid = c_valid && src_valid;
  assign stg_data  = src_data;
  assign c_ready   = stg_ready && src_valid;
  assign a_ready   = c_valid && stg_ready && (pick == PICK_A);
  assign b_ready   = c_valid && stg_ready && (pick == PICK_B);

  assert_no_ready_idle_R1: assert property (@(posedge clk) disable iff (rst)
    !c_valid |-> !(a_ready || b_ready));

  assert_zero_takes_a_R2: assert property (@(posedge clk) disable iff (rst)
    (c_valid && c_ready && (c_data == '0)) |-> (a_valid && a_ready));

  assert_nonzero_takes_b_R2: assert property (@(posedge clk) disable iff (rst)
    (c_valid && c_ready && (c_data != '0)) |-> (b_valid && b_ready));

  assert_one_side_R4: assert property (@(posedge clk) disable iff (rst)
    !(a_ready && b_ready));

  assert_data_needs_ctrl_R9: assert property (@(posedge clk) disable iff (rst)
    ((a_valid && a_ready) || (b_valid && b_ready)) |-> (c_valid && c_ready));
endmodule

// File: rtl/merge_outstage.sv
module merge_outstage #(
  parameter int DW      = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  input  logic          out_ready
);
  generate
    if (OUT_REG) begin : g_reg
      logic          v_q;
      logic [DW-1:0] d_q;

      always_ff @(posedge clk) begin
        if (rst)                       v_q <= 1'b0;
        else if (in_valid && in_ready) v_q <= 1'b1;
        else if (out_ready)            v_q <= 1'b0;
      end

      // payload register carries no reset so it maps onto plain flops
      always_ff @(posedge clk) begin
        if (in_valid && in_ready) d_q <= in_data;
      end

      assign in_ready  = !v_q || out_ready;
      assign out_valid = v_q;
      assign out_data  = d_q;

      assert_load_shows_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |=> out_valid);

      assert_hold_stalled_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

      assert_reset_empty_R8: assert property (@(posedge clk)
        $past(rst) |-> !out_valid);
    end else begin : g_pass
      assign in_ready  = out_ready;
      assign out_valid = in_valid;
      assign out_data  = in_data;
    end
  endgenerate
endmodule

// File: rtl/tok_merge.sv
module tok_merge #(
  parameter int DW      = 8,
  parameter int CW      = 2,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          c_valid,
  output logic          c_ready,
  input  logic [CW-1:0] c_data,
  input  logic          a_valid,
  output logic          a_ready,
  input  logic [DW-1:0] a_data,
  input  logic          b_valid,
  output logic          b_ready,
  input  logic [DW-1:0] b_data,
  output logic          z_valid,
  input  logic          z_ready,
  output logic [DW-1:0] z_data
);
  logic          stg_valid;
  logic          stg_ready;
  logic [DW-1:0] stg_data;

  merge_steer #(.DW(DW), .CW(CW)) u_steer (
    .clk       (clk),
    .rst       (rst),
    .c_valid   (c_valid),
    .c_data    (c_data),
    .c_ready   (c_ready),
    .a_valid   (a_valid),
    .a_data    (a_data),
    .a_ready   (a_ready),
    .b_valid   (b_valid),
    .b_data    (b_data),
    .b_ready   (b_ready),
    .stg_ready (stg_ready),
    .stg_valid (stg_valid),
    .stg_data  (stg_data)
  );

  merge_outstage #(.DW(DW), .OUT_REG(OUT_REG)) u_out (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (stg_valid),
    .in_data   (stg_data),
    .in_ready  (stg_ready),
    .out_valid (z_valid),
    .out_data  (z_data),
    .out_ready (z_ready)
  );

  assert_ctrl_blocked_R7: assert property (@(posedge clk) disable iff (rst)
    (OUT_REG && z_valid && !z_ready) |-> !(c_valid && c_ready));
endmodule

// File: tb/sim_tok_merge.sv
module sim_tok_merge;
  localparam int DW = 8;
  localparam int CW = 2;
  localparam int QN = 4096;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic          c_valid = 0, c_ready;
  logic [CW-1:0] c_data = '0;
  logic          a_valid = 0, a_ready;
  logic [DW-1:0] a_data = '0;
  logic          b_valid = 0, b_ready;
  logic [DW-1:0] b_data = '0;
  logic          z_valid, z_ready = 0;
  logic [DW-1:0] z_data;

  tok_merge #(.DW(DW), .CW(CW), .OUT_REG(1'b1)) u0 (
    .clk(clk), .rst(rst),
    .c_valid(c_valid), .c_ready(c_ready), .c_data(c_data),
    .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data),
    .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data),
    .z_valid(z_valid), .z_ready(z_ready), .z_data(z_data)
  );

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] expq [0:QN-1];
  int wr = 0, rd = 0, ci = 0, ai = 0, bi = 0;
  logic [15:0] lfsr = 16'hACE1;
  logic pz_v = 0, pz_r = 0, pfire = 0;
  logic [DW-1:0] pz_d = '0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] a_tok(input int k);
    return DW'(k * 37 + 11);
  endfunction

  function automatic logic [DW-1:0] b_tok(input int k);
    return DW'(k * 53 + 200);
  endfunction

  function automatic logic [CW-1:0] ctl_of(input int mode, input int k);
    case (mode)
      0:       return CW'((k * 7 + k / 4) % 4);
      2:       return CW'(1 + k % 3);
      3:       return CW'((k * k + k / 3) % 4);
      default: return '0;
    endcase
  endfunction

  // modes: 0 full sweep, 1 B parked under zero controls, 2 A empty,
  // 3 random gaps and stalls, 4 idle drain, 6 stall a single A token
  task automatic step(input int mode, input int cyc);
    bit cf, af, bf, zf, selv, selr;
    @(negedge clk);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    c_data = ctl_of(mode, ci);
    a_data = a_tok(ai);
    b_data = b_tok(bi);
    case (mode)
      0: begin c_valid = 1; a_valid = 1; b_valid = 1; z_ready = 1; end
      1: begin c_valid = (cyc % 4) != 3; a_valid = lfsr[3]; b_valid = 1;
               z_ready = (cyc % 3) != 0; end
      2: begin c_valid = 1; a_valid = 0; b_valid = (cyc % 5) != 0;
               z_ready = (cyc % 2) == 0; end
      3: begin c_valid = lfsr[0]; a_valid = lfsr[1]; b_valid = lfsr[2];
               z_ready = lfsr[4] | lfsr[5]; end
      6: begin c_valid = 1; a_valid = 1; b_valid = 0; z_ready = 0; end
      default: begin c_valid = 0; a_valid = 0; b_valid = 0; z_ready = 1; end
    endcase
    #2;
    cf = c_valid && c_ready;
    af = a_valid && a_ready;
    bf = b_valid && b_ready;
    zf = z_valid && z_ready;
    if (!c_valid)
      chk(!a_ready && !b_ready, "R1", "data ready without control",
          int'({a_ready, b_ready}), 0);
    if (c_valid && c_data == '0)
      chk(!b_ready, "R4", "B ready while A selected", int'(b_ready), 0);
    if (c_valid && c_data != '0)
      chk(!a_ready, "R4", "A ready while B selected", int'(a_ready), 0);
    if (c_valid) begin
      selv = (c_data == '0) ? a_valid : b_valid;
      selr = (c_data == '0) ? a_ready : b_ready;
      chk(cf == (selv && selr), "R9", "control vs data consume",
          int'(cf), int'(selv && selr));
      if (cf)
        chk((c_data == '0) ? af : bf, "R2", "wrong input consumed",
            int'({af, bf}), (c_data == '0) ? 2 : 1);
    end
    if (mode == 2 && c_valid && b_valid && (!z_valid || z_ready))
      chk(c_ready, "R5", "transfer blocked by empty A", int'(c_ready), 1);
    if (z_valid && !z_ready)
      chk(!cf, "R7", "control consumed while Z stalled full", int'(cf), 0);
    if (pz_v && !pz_r)
      chk(z_valid && z_data == pz_d, "R7", "stalled output changed",
          int'(z_data), int'(pz_d));
    if (pfire)
      chk(z_valid, "R3", "accepted token not shown", int'(z_valid), 1);
    if (zf) begin
      chk(rd < wr, "R6", "extra output token", rd, wr);
      if (rd < wr) begin
        chk(z_data == expq[rd % QN], "R6", "output data/order",
            int'(z_data), int'(expq[rd % QN]));
        rd++;
      end
    end
    if (cf) begin
      expq[wr % QN] = (c_data == '0) ? a_data : b_data;
      wr++;
      ci++;
    end
    if (af) ai++;
    if (bf) bi++;
    pz_v = z_valid; pz_r = z_ready; pz_d = z_data; pfire = cf;
  endtask

  task automatic drain();
    for (int i = 0; i < 6; i++) step(4, i);
    chk(rd == wr, "R6", "tokens lost after drain", rd, wr);
  endtask

  task automatic report();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    int b_hold;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!z_valid, "R8", "z_valid during reset", int'(z_valid), 0);
    chk(!a_ready && !b_ready, "R1", "ready with no control",
        int'({a_ready, b_ready}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!z_valid, "R8", "z_valid after reset", int'(z_valid), 0);

    for (int i = 0; i < 200; i++) step(0, i);
    drain();

    b_hold = bi;
    for (int i = 0; i < 300; i++) step(1, i);
    chk(bi == b_hold, "R4", "parked B token consumed", bi, b_hold);
    chk(b_valid && !b_ready, "R4", "parked B token still pending",
        int'(b_ready), 0);
    drain();

    for (int i = 0; i < 200; i++) step(2, i);
    drain();

    for (int i = 0; i < 3000; i++) step(3, i);
    drain();

    for (int i = 0; i < 3; i++) step(6, i);
    chk(z_valid, "R7", "stalled token present", int'(z_valid), 1);
    @(negedge clk);
    rst = 1'b1; c_valid = 0; a_valid = 0; b_valid = 0;
    @(negedge clk);
    rst = 1'b0;
    chk(!z_valid, "R8", "reset did not empty output", int'(z_valid), 0);
    rd = wr; pz_v = 0; pfire = 0;
    for (int i = 0; i < 100; i++) step(0, i);
    drain();

    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog run did not finish actual=%0d expected=%0d", 1, 0);
    report();
    $finish;
  end
endmodule